// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block is a hardware breakpoint comparator that sits beside a 32-bit processor core. It watches two observation streams. The first is the program counter of each executed instruction. The second is the address and data of each operand bus access. Each observed value is compared against programmable reference registers through a mask. A mask bit of 1 removes that bit from the comparison. The program-counter side has several reference registers and one mask that all of them share.

The comparator results feed a trigger sequencer. In single-level mode, any enabled hit fires the trigger while the unit is armed. In two-level mode, a first condition (chosen as either the PC side or the bus side) must hit before the other condition is watched. The second condition must then hit on a later beat. After a two-level trigger fires, the unit disarms itself. A fired trigger produces a one-cycle pulse on either the halt request or the debug interrupt request, chosen by a control bit.

Configuration goes through a simple register write/read port. Both observation inputs are valid-only streams with no ready signal. The monitor takes every beat in the cycle it is presented, so it never applies back-pressure and never stalls the core.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, every register reads 0, both request outputs are 0, and the unit is disarmed.
- R2: Register index map: 0 address reference, 1 address mask, 2 data reference, 3 data mask, 4..7 PC references 0..3, 8 PC mask, 9 control. Indices 0..8 read back exactly what was written. Control bits [8:0] read back as written, and bit 9 reads the armed status.
- R3: A comparison ignores every bit whose mask bit is 1 and requires equality on every other bit.
- R4: The PC mask applies to all four PC comparators. PC comparator i takes part only when control bit 2+i is set. A PC value is considered only while pc_valid is high.
- R5: The bus condition is considered only while bus_valid is high. The address comparator (enable bit 0) and the data comparator (enable bit 1) must both match on the same access when both are enabled. A disabled comparator is ignored. With neither enabled, there is no bus hit.
- R6: In single-level mode (bit 6 = 0), every beat with a PC hit or a bus hit, while armed, gives a request in the cycle after the beat.
- R7: In two-level mode (bit 6 = 1), the first condition is the PC side when bit 8 = 0 and the bus side when bit 8 = 1. The other side fires the trigger only on a beat after the first one hit. Second-side hits before that, or on the same beat as the first hit, give nothing.
- R8: After a two-level trigger fires, the unit is disarmed. It stays quiet until control is rewritten with bit 9 set.
- R9: Bit 7 selects the action: 0 pulses halt_req and 1 pulses dbg_irq_req. The two outputs are never high together.
- R10: Writing control with bit 9 = 0 disarms the unit. A control write takes precedence over a hit on the same cycle, and that hit gives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| pc_valid | input | 1 | Executed-PC beat valid |
| pc_value | input | 32 | Executed program counter |
| bus_valid | input | 1 | Operand access beat valid |
| bus_addr | input | 32 | Operand access address |
| bus_data | input | 32 | Operand access data |
| halt_req | output | 1 | One-cycle halt request pulse |
| dbg_irq_req | output | 1 | One-cycle debug interrupt request pulse |

## Verification
The bench uses patterns whose only difference lies in masked bits, to show that the masks work. A design with an inverted mask sense would fire on the wrong address. It also drives a PC value equal to a disabled reference, which exposes a design that ignores the per-comparator enables. The two-level cases send the second-side hit before the first, on the same beat as the first, and again after a fire. Each of these must stay silent, so a design that does not arm in order, or does not disarm after firing, shows a stray pulse. A control write that lands on the same cycle as a hit checks the precedence rule, and the action bit is exercised both ways.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } trig_state_t;

  function automatic logic masked_eq(input logic [31:0] a, input logic [31:0] r,
                                     input logic [31:0] m);
    return ((a ^ r) & ~m) == '0;
  endfunction
endpackage

// File: rtl/dbg_mask_cmp.sv
module dbg_mask_cmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] refv,
  input  logic [W-1:0] mask,
  output logic         hit
);
  // mask bit 1 removes the bit from the equality test
  assign hit = ~|((value ^ refv) & ~mask);
endmodule

// File: rtl/dbg_trig_regs.sv
module dbg_trig_regs #(
  parameter int DW  = 32,
  parameter int NPC = 4,
  parameter int IW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          idx,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic                   armed,
  output logic [DW-1:0]          a_ref,
  output logic [DW-1:0]          a_msk,
  output logic [DW-1:0]          d_ref,
  output logic [DW-1:0]          d_msk,
  output logic [NPC-1:0][DW-1:0] p_ref,
  output logic [DW-1:0]          p_msk,
  output logic [NPC+4:0]         ctrl,
  output logic                   ctrl_wr,
  output logic                   arm_bit
);
  localparam int NDATA = NPC + 5;          // data registers before control
  localparam int CTRL_IDX = NDATA;
  localparam int CW = NPC + 5;             // stored control bits

  logic [DW-1:0] reg_q [NDATA];
  logic [CW-1:0] ctrl_q;

  assign ctrl_wr = wr_en && (idx == IW'(CTRL_IDX));
  assign arm_bit = wdata[CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NDATA; k++) reg_q[k] <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (ctrl_wr) ctrl_q <= wdata[CW-1:0];
      else if (idx < IW'(NDATA)) reg_q[idx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (idx == IW'(CTRL_IDX)) rdata = {{(DW-CW-1){1'b0}}, armed, ctrl_q};
    else if (idx < IW'(NDATA)) rdata = reg_q[idx];
  end

  assign a_ref = reg_q[0];
  assign a_msk = reg_q[1];
  assign d_ref = reg_q[2];
  assign d_msk = reg_q[3];
  assign p_msk = reg_q[NPC+4];
  assign ctrl  = ctrl_q;

  for (genvar g = 0; g < NPC; g++) begin : g_pcref
    assign p_ref[g] = reg_q[4+g];
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic arm_bit,
  input  logic two_lvl,
  input  logic first_bus,
  input  logic act_irq,
  input  logic pc_hit,
  input  logic bus_hit,
  output logic armed,
  output logic halt_req,
  output logic irq_req
);
  trig_state_t st_q, st_d;
  logic fire, first_hit, second_hit;

  assign first_hit  = first_bus ? bus_hit : pc_hit;
  assign second_hit = first_bus ? pc_hit  : bus_hit;
  assign armed      = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    if (ctrl_wr) begin
      st_d = arm_bit ? ST_FIRST : ST_IDLE;
    end else begin
      case (st_q)
        ST_FIRST: begin
          if (!two_lvl) fire = pc_hit | bus_hit;
          else if (first_hit) st_d = ST_SECOND;
        end
        ST_SECOND: begin
          if (second_hit) begin
            fire = 1'b1;
            st_d = ST_IDLE;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      halt_req <= 1'b0;
      irq_req  <= 1'b0;
    end else begin
      st_q     <= st_d;
      halt_req <= fire & ~act_irq;
      irq_req  <= fire & act_irq;
    end
  end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit #(
  parameter int DW  = 32,
  parameter int NPC = 4,
  parameter int IW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [IW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          pc_valid,
  input  logic [DW-1:0] pc_value,
  input  logic          bus_valid,
  input  logic [DW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          halt_req,
  output logic          dbg_irq_req
);
  localparam int B_AEN   = 0;
  localparam int B_DEN   = 1;
  localparam int B_PEN   = 2;
  localparam int B_TWO   = NPC + 2;
  localparam int B_ACT   = NPC + 3;
  localparam int B_FIRST = NPC + 4;

  logic [DW-1:0]          a_ref, a_msk, d_ref, d_msk, p_msk;
  logic [NPC-1:0][DW-1:0] p_ref;
  logic [NPC+4:0]         ctrl;
  logic                   ctrl_wr, arm_bit, armed, two_lvl;
  logic                   a_hit, d_hit, pc_hit, bus_hit;
  logic [NPC-1:0]         p_hit;

  dbg_trig_regs #(.DW(DW), .NPC(NPC), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .idx(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .armed(armed),
    .a_ref(a_ref), .a_msk(a_msk), .d_ref(d_ref), .d_msk(d_msk),
    .p_ref(p_ref), .p_msk(p_msk), .ctrl(ctrl), .ctrl_wr(ctrl_wr),
    .arm_bit(arm_bit)
  );

  dbg_mask_cmp #(.W(DW)) u_acmp (.value(bus_addr), .refv(a_ref), .mask(a_msk), .hit(a_hit));
  dbg_mask_cmp #(.W(DW)) u_dcmp (.value(bus_data), .refv(d_ref), .mask(d_msk), .hit(d_hit));

  for (genvar g = 0; g < NPC; g++) begin : g_pccmp
    dbg_mask_cmp #(.W(DW)) u_pcmp (
      .value(pc_value), .refv(p_ref[g]), .mask(p_msk), .hit(p_hit[g])
    );
  end

  assign two_lvl = ctrl[B_TWO];
  assign pc_hit  = pc_valid && |(p_hit & ctrl[B_PEN +: NPC]);
  assign bus_hit = bus_valid && (ctrl[B_AEN] || ctrl[B_DEN])
                   && (!ctrl[B_AEN] || a_hit) && (!ctrl[B_DEN] || d_hit);

  dbg_trig_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .arm_bit(arm_bit),
    .two_lvl(two_lvl), .first_bus(ctrl[B_FIRST]), .act_irq(ctrl[B_ACT]),
    .pc_hit(pc_hit), .bus_hit(bus_hit), .armed(armed),
    .halt_req(halt_req), .irq_req(dbg_irq_req)
  );
endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_req,
  input logic irq_req,
  input logic armed,
  input logic two_lvl,
  input logic ctrl_wr,
  input logic pc_hit,
  input logic bus_hit
);
  // R9
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_req && irq_req));

  // R10
  quiet_when_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !(halt_req || irq_req));

  // R8
  disarm_after_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((halt_req || irq_req) && two_lvl) |-> !armed);

  // R6
  single_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !two_lvl && !ctrl_wr && (pc_hit || bus_hit)) |=> (halt_req || irq_req));
endmodule

bind dbg_trig_unit dbg_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .irq_req(dbg_irq_req),
  .armed(armed), .two_lvl(two_lvl), .ctrl_wr(ctrl_wr),
  .pc_hit(pc_hit), .bus_hit(bus_hit)
);

// File: tb/dbg_trig_unit_test.sv
`timescale 1ns/1ps
module dbg_trig_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pc_valid = 1'b0, bus_valid = 1'b0;
  logic [31:0] pc_value = '0, bus_addr = '0, bus_data = '0;
  logic        halt_req, dbg_irq_req;

  int checks = 0;
  int fails  = 0;

  // control encodings (R2, R4, R5, R6, R7, R9)
  localparam logic [31:0] C_AEN   = 32'h001;
  localparam logic [31:0] C_DEN   = 32'h002;
  localparam logic [31:0] C_TWO   = 32'h040;
  localparam logic [31:0] C_IRQ   = 32'h080;
  localparam logic [31:0] C_BUS1  = 32'h100;
  localparam logic [31:0] C_ARM   = 32'h200;

  always #5 clk = ~clk;

  dbg_trig_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pc_valid(pc_valid),
    .pc_value(pc_value), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .halt_req(halt_req), .dbg_irq_req(dbg_irq_req)
  );

  function automatic logic [31:0] pcen(input int i);
    return 32'h4 << i;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 check(req, $sformatf("read idx %0d", a), cfg_rdata, exp);
  endtask

  // one observation beat; returns {halt, irq} seen the cycle after
  task automatic beat(input logic pv, input logic [31:0] pc, input logic bv,
                      input logic [31:0] ba, input logic [31:0] bd,
                      output logic [1:0] req);
    @(negedge clk);
    pc_valid = pv; pc_value = pc; bus_valid = bv; bus_addr = ba; bus_data = bd;
    @(negedge clk);
    req = {halt_req, dbg_irq_req};
    pc_valid = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 10; k++) rd_chk("R1", 4'(k), 32'h0);
    check("R1", "outputs idle", {30'h0, halt_req, dbg_irq_req}, 32'h0);
  endtask

  task automatic t_regs;
    for (int k = 0; k < 9; k++) wr(4'(k), 32'hA5000000 + 32'(k * 32'h1111));
    for (int k = 0; k < 9; k++) rd_chk("R2", 4'(k), 32'hA5000000 + 32'(k * 32'h1111));
    wr(4'd9, 32'h1FF | C_ARM);
    rd_chk("R2", 4'd9, 32'h3FF);
    wr(4'd9, 32'h0);
    rd_chk("R10", 4'd9, 32'h0);
  endtask

  task automatic t_mask;
    logic [1:0] r;
    wr(4'd0, 32'h1000_0000); wr(4'd1, 32'h0000_00FF);
    wr(4'd9, C_AEN | C_ARM);
    beat(1'b0, 0, 1'b1, 32'h1000_00AB, 32'h0, r);
    check("R3", "masked bits differ -> halt", {30'h0, r}, 32'h2);
    beat(1'b0, 0, 1'b1, 32'h1000_0100, 32'h0, r);
    check("R3", "unmasked bit differs", {30'h0, r}, 32'h0);
    beat(1'b0, 0, 1'b0, 32'h1000_0000, 32'h0, r);
    check("R5", "bus_valid low", {30'h0, r}, 32'h0);
  endtask

  task automatic t_pc;
    logic [1:0] r;
    wr(4'd4, 32'h0000_1000); wr(4'd5, 32'h0000_2000);
    wr(4'd6, 32'h0000_3000); wr(4'd7, 32'h0000_4000);
    wr(4'd8, 32'h0000_0003);
    wr(4'd9, pcen(0) | pcen(2) | C_ARM);
    beat(1'b1, 32'h0000_3002, 1'b0, 0, 0, r);
    check("R4", "pc2 hit under shared mask", {30'h0, r}, 32'h2);
    beat(1'b1, 32'h0000_1001, 1'b0, 0, 0, r);
    check("R4", "pc0 hit under shared mask", {30'h0, r}, 32'h2);
    beat(1'b1, 32'h0000_2000, 1'b0, 0, 0, r);
    check("R4", "disabled pc1 ignored", {30'h0, r}, 32'h0);
    beat(1'b0, 32'h0000_1000, 1'b0, 0, 0, r);
    check("R4", "pc_valid low", {30'h0, r}, 32'h0);
    beat(1'b1, 32'h0000_3004, 1'b0, 0, 0, r);
    check("R4", "bit outside mask", {30'h0, r}, 32'h0);
  endtask

  task automatic t_bus;
    logic [1:0] r;
    wr(4'd1, 32'h0); wr(4'd2, 32'hDEAD_BEEF); wr(4'd3, 32'h0);
    wr(4'd9, C_AEN | C_DEN | C_IRQ | C_ARM);
    beat(1'b0, 0, 1'b1, 32'h1000_0000, 32'hDEAD_BEEE, r);
    check("R5", "addr ok data bad", {30'h0, r}, 32'h0);
    beat(1'b0, 0, 1'b1, 32'h1000_0004, 32'hDEAD_BEEF, r);
    check("R5", "data ok addr bad", {30'h0, r}, 32'h0);
    beat(1'b0, 0, 1'b1, 32'h1000_0000, 32'hDEAD_BEEF, r);
    check("R9", "both match -> irq only", {30'h0, r}, 32'h1);
    wr(4'd9, C_DEN | C_ARM);
    beat(1'b0, 0, 1'b1, 32'h7777_0000, 32'hDEAD_BEEF, r);
    check("R5", "data-only ignores addr", {30'h0, r}, 32'h2);
    wr(4'd9, C_ARM);
    beat(1'b0, 0, 1'b1, 32'h1000_0000, 32'hDEAD_BEEF, r);
    check("R5", "no bus enable", {30'h0, r}, 32'h0);
  endtask

  task automatic t_two;
    logic [1:0] r;
    // PC ref0 = 0x1000 (mask 3), addr ref 0x1000_0000 exact
    wr(4'd9, C_AEN | pcen(0) | C_TWO | C_ARM);
    beat(1'b0, 0, 1'b1, 32'h1000_0000, 0, r);
    check("R7", "second before first", {30'h0, r}, 32'h0);
    beat(1'b1, 32'h0000_1000, 1'b0, 0, 0, r);
    check("R7", "first level alone", {30'h0, r}, 32'h0);
    beat(1'b0, 0, 1'b1, 32'h1000_0000, 0, r);
    check("R7", "second after first", {30'h0, r}, 32'h2);
    rd_chk("R8", 4'd9, C_AEN | pcen(0) | C_TWO);
    beat(1'b1, 32'h0000_1000, 1'b0, 0, 0, r);
    beat(1'b0, 0, 1'b1, 32'h1000_0000, 0, r);
    check("R8", "disarmed after fire", {30'h0, r}, 32'h0);
    wr(4'd9, C_AEN | pcen(0) | C_TWO | C_ARM);
    beat(1'b1, 32'h0000_1000, 1'b1, 32'h1000_0000, 0, r);
    check("R7", "same-beat second ignored", {30'h0, r}, 32'h0);
    beat(1'b0, 0, 1'b1, 32'h1000_0000, 0, r);
    check("R7", "later second fires", {30'h0, r}, 32'h2);
    // bus side first, irq action
    wr(4'd9, C_AEN | pcen(0) | C_TWO | C_BUS1 | C_IRQ | C_ARM);
    beat(1'b1, 32'h0000_1000, 1'b0, 0, 0, r);
    check("R7", "pc before bus-first", {30'h0, r}, 32'h0);
    beat(1'b0, 0, 1'b1, 32'h1000_0000, 0, r);
    beat(1'b1, 32'h0000_1000, 1'b0, 0, 0, r);
    check("R9", "bus-first then pc -> irq", {30'h0, r}, 32'h1);
  endtask

  task automatic t_disarm;
    logic [1:0] r;
    wr(4'd9, pcen(0));
    beat(1'b1, 32'h0000_1000, 1'b0, 0, 0, r);
    check("R10", "disarmed hit", {30'h0, r}, 32'h0);
    wr(4'd9, pcen(0) | C_ARM);
    // control write on the same cycle as a hit
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 4'd9; cfg_wdata = pcen(0) | C_ARM;
    pc_valid = 1'b1; pc_value = 32'h0000_1000;
    @(negedge clk);
    cfg_wr_en = 1'b0; pc_valid = 1'b0;
    check("R10", "write wins over hit", {30'h0, halt_req, dbg_irq_req}, 32'h0);
    beat(1'b1, 32'h0000_1000, 1'b0, 0, 0, r);
    check("R6", "next hit fires", {30'h0, r}, 32'h2);
    @(negedge clk);
    check("R9", "pulse is one cycle", {30'h0, halt_req, dbg_irq_req}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_mask;
    t_pc;
    t_bus;
    t_two;
    t_disarm;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule